// File: doc/BRIEF.md
# AXI Burst Splitter

This block takes one transfer descriptor and turns it into a series of AXI4 address-channel requests. A descriptor has four fields: a start address, a byte count, an addressing mode and a burst-length cap. The addressing mode is either constant address (FIXED) or incrementing address (INCR). The cap is given as the largest allowed AxLEN. Each request the block emits carries a start address, AxLEN, AxSIZE and AxBURST. A request is held on a valid/ready pair until the AXI master port accepts it. A single-cycle `done` pulse marks the end of the descriptor. One instance drives the read address path and a second instance drives the write address path. Data beats and responses are handled elsewhere.

The start address is rounded down to the bus width. The byte count is rounded up to whole beats, so every beat is a full bus-width transfer. Each burst is made as long as possible, limited by four things at once:
- the beats left before the next 4 KB boundary (INCR only),
- the mode limit (16 beats for FIXED, 256 for INCR),
- the programmed cap,
- the beats still owed.

The controller has four states, with the following transitions:
- IDLE waits for a descriptor. It goes to CALC when it accepts a non-empty descriptor, and straight to DONE when it accepts a zero-byte one.
- CALC spends one cycle sizing the next burst and loading the request registers, then goes to ISSUE.
- ISSUE holds the request valid until the handshake. It then returns to CALC if beats remain, or goes to DONE if none remain.
- DONE raises `done` for one cycle and returns to IDLE.

Top module: `burst_chopper`

## Requirements
- R1: `desc_ready` is high only in IDLE. A descriptor presented while the block is busy is ignored and produces no requests.
- R2: The first request address is the descriptor address with its low log2(DATA_W/8) bits cleared. The beats summed over all requests equal ceil(byte count / (DATA_W/8)).
- R3: In INCR mode no request crosses a 4 KB boundary: (req_addr mod 4096) + (req_len+1)·(DATA_W/8) ≤ 4096.
- R4: A FIXED request has req_len ≤ 15. An INCR request has req_len ≤ 255.
- R5: Every request has req_len ≤ the cap value sampled when the descriptor was accepted. Later changes on `cap_len` have no effect.
- R6: Each burst has the largest length allowed by the 4 KB room (INCR only), the mode limit, the cap and the beats remaining.
- R7: In FIXED mode every request repeats the aligned start address. In INCR mode each request starts at the previous address plus (previous req_len+1)·(DATA_W/8).
- R8: req_len is beats−1. req_size is log2(DATA_W/8). req_burst is 2'b00 for FIXED and 2'b01 for INCR.
- R9: While `req_valid` is high and `req_ready` is low, the request stays valid and its fields stay unchanged.
- R10: `done` is high for exactly one cycle, in the cycle after the final request handshake. For a zero-byte descriptor, `done` is high in the cycle after acceptance and no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken (IDLE) |
| desc_addr | input | ADDR_W | Start byte address |
| desc_bytes | input | BYTES_W | Byte count |
| desc_incr | input | 1 | 1 = INCR mode, 0 = FIXED mode |
| cap_len | input | 8 | Largest AxLEN allowed, sampled on accept |
| req_valid | output | 1 | Address request valid |
| req_ready | input | 1 | Address request accepted |
| req_addr | output | ADDR_W | Burst start address |
| req_len | output | 8 | AxLEN (beats minus one) |
| req_size | output | 3 | AxSIZE |
| req_burst | output | 2 | AxBURST |
| done | output | 1 | One-cycle end-of-descriptor pulse |

## Verification
Errors in the state register or in the remaining-beat count show up at the ports in one of three ways:
- a request that is too long or too short, caught at its own handshake;
- a `done` pulse that comes one request early or late;
- a `desc_ready` that rises while requests are still owed.

A corrupted running address shows up on the very next INCR request as a wrong start address. Each handshake is compared with a bench model of the greedy length rule, so a fault is reported at the first burst it affects. The corner cases covered are:
- 4 KB edges;
- the 16-beat FIXED limit;
- a cap of zero;
- unaligned starts;
- an empty descriptor.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CALC  = 2'd1,
        ST_ISSUE = 2'd2,
        ST_DONE  = 2'd3
    } chop_state_e;

    localparam logic [1:0] BURST_FIXED = 2'b00;
    localparam logic [1:0] BURST_INCR  = 2'b01;

    localparam int unsigned PAGE_BYTES   = 4096;
    localparam int unsigned FIXED_BEATS  = 16;
    localparam int unsigned INCR_BEATS   = 256;
endpackage

// File: rtl/beat_round.sv
module beat_round #(
    parameter int ADDR_W  = 32,
    parameter int BYTES_W = 32,
    parameter int SZ      = 2,
    localparam int CNT_W  = BYTES_W + 1 - SZ
) (
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic [BYTES_W-1:0] bytes_in,
    output logic [ADDR_W-1:0]  addr_aligned,
    output logic [CNT_W-1:0]   beats_out
);
    localparam logic [BYTES_W:0] ROUND_ADD = (BYTES_W+1)'((1 << SZ) - 1);

    logic [BYTES_W:0] padded;

    always_comb begin
        padded       = {1'b0, bytes_in} + ROUND_ADD;
        beats_out    = padded[BYTES_W:SZ];
        addr_aligned = addr_in & ~ADDR_W'((1 << SZ) - 1);
    end
endmodule

// File: rtl/burst_len_calc.sv
module burst_len_calc
    import burst_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 31,
    parameter int SZ     = 2
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CNT_W-1:0]  beats_left,
    input  logic              incr_mode,
    input  logic [7:0]        cap,
    output logic [8:0]        beats
);
    localparam int LW = 14;

    logic [LW-1:0] room_bytes;
    logic [LW-1:0] room_beats;
    logic [LW-1:0] cap_beats;
    logic [LW-1:0] lim;

    always_comb begin
        room_bytes = LW'(PAGE_BYTES) - LW'(cur_addr[11:0]);
        room_beats = room_bytes >> SZ;
        cap_beats  = LW'(cap) + LW'(1);
        lim        = incr_mode ? LW'(INCR_BEATS) : LW'(FIXED_BEATS);
        if (incr_mode && room_beats < lim) lim = room_beats;
        if (cap_beats < lim)               lim = cap_beats;
        if (beats_left < CNT_W'(lim))      lim = LW'(beats_left);
        beats = lim[8:0];
    end
endmodule

// File: rtl/burst_chopper.sv
module burst_chopper
    import burst_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int BYTES_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               desc_valid,
    output logic               desc_ready,
    input  logic [ADDR_W-1:0]  desc_addr,
    input  logic [BYTES_W-1:0] desc_bytes,
    input  logic               desc_incr,
    input  logic [7:0]         cap_len,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [7:0]         req_len,
    output logic [2:0]         req_size,
    output logic [1:0]         req_burst,
    output logic               done
);
    localparam int BUS_BYTES = DATA_W / 8;
    localparam int SZ        = $clog2(BUS_BYTES);
    localparam int CNT_W     = BYTES_W + 1 - SZ;

    chop_state_e state_q, state_d;

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  rem_q;
    logic              incr_q;
    logic [7:0]        cap_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [7:0]        req_len_q;

    logic [ADDR_W-1:0] addr_aligned;
    logic [CNT_W-1:0]  desc_beats;
    logic [8:0]        next_beats;
    logic              accept;
    logic              handshake;

    beat_round #(.ADDR_W(ADDR_W), .BYTES_W(BYTES_W), .SZ(SZ)) u_round (
        .addr_in      (desc_addr),
        .bytes_in     (desc_bytes),
        .addr_aligned (addr_aligned),
        .beats_out    (desc_beats)
    );

    burst_len_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SZ(SZ)) u_len (
        .cur_addr   (base_q),
        .beats_left (rem_q),
        .incr_mode  (incr_q),
        .cap        (cap_q),
        .beats      (next_beats)
    );

    assign accept    = desc_valid && desc_ready;
    assign handshake = req_valid && req_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = (desc_beats == '0) ? ST_DONE : ST_CALC;
            ST_CALC:  state_d = ST_ISSUE;
            ST_ISSUE: if (handshake) state_d = (rem_q == '0) ? ST_DONE : ST_CALC;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        desc_ready = 1'b0;
        req_valid  = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE:  desc_ready = 1'b1;
            ST_CALC:  ;
            ST_ISSUE: req_valid  = 1'b1;
            ST_DONE:  done       = 1'b1;
            default:  ;
        endcase
    end

    assign req_addr  = req_addr_q;
    assign req_len   = req_len_q;
    assign req_size  = 3'(SZ);
    assign req_burst = incr_q ? BURST_INCR : BURST_FIXED;

    // descriptor tracking and request registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q     <= '0;
            rem_q      <= '0;
            incr_q     <= 1'b0;
            cap_q      <= '0;
            req_addr_q <= '0;
            req_len_q  <= '0;
        end else if (state_q == ST_IDLE && accept) begin
            base_q <= addr_aligned;
            rem_q  <= desc_beats;
            incr_q <= desc_incr;
            cap_q  <= cap_len;
        end else if (state_q == ST_CALC) begin
            req_addr_q <= base_q;
            req_len_q  <= 8'(next_beats - 9'd1);
            rem_q      <= rem_q - CNT_W'(next_beats);
            if (incr_q) base_q <= base_q + (ADDR_W'(next_beats) << SZ);
        end
    end

    // checks
    logic [13:0] chk_end;
    assign chk_end = 14'(req_addr_q[11:0]) + ((14'(req_len_q) + 14'd1) << SZ);

    AST_DESC_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ready |-> !req_valid && !done);                                   // R1
    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_addr[SZ-1:0] == '0);                                 // R2
    AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_burst == BURST_INCR) |-> chk_end <= 14'd4096);        // R3
    AST_FIXED_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_burst == BURST_FIXED) |-> req_len <= 8'd15);          // R4
    AST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_len <= cap_q);                                       // R5
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid && $stable(req_addr) && $stable(req_len)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                       // R10
endmodule

// File: tb/burst_chopper_bench.sv
module burst_chopper_bench;
    localparam int ADDR_W = 32, DATA_W = 32, BYTES_W = 32;
    localparam int BB = DATA_W / 8;
    localparam int SZ = $clog2(BB);

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, desc_valid, desc_ready, desc_incr, req_valid, req_ready, done;
    logic [ADDR_W-1:0] desc_addr, req_addr;
    logic [BYTES_W-1:0] desc_bytes;
    logic [7:0] cap_len, req_len;
    logic [2:0] req_size;
    logic [1:0] req_burst;

    burst_chopper #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTES_W(BYTES_W)) u_burst_chopper (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_addr(desc_addr), .desc_bytes(desc_bytes), .desc_incr(desc_incr),
        .cap_len(cap_len), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_size(req_size),
        .req_burst(req_burst), .done(done)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_beats(input logic [31:0] a, input longint rem,
                                     input bit incr, input int cap);
        int lim;
        int room;
        lim = incr ? 256 : 16;
        room = (4096 - int'(a[11:0])) / BB;
        if (incr && room < lim) lim = room;
        if (cap + 1 < lim) lim = cap + 1;
        if (rem < lim) lim = int'(rem);
        return lim;
    endfunction

    task automatic run_desc(input logic [31:0] addr, input logic [31:0] bytes,
                            input bit incr, input int cap, input bit junk);
        logic [31:0] a;
        longint rem, total, sum;
        int n;
        bit held;
        logic [31:0] h_addr;
        logic [7:0] h_len;
        @(negedge clk);
        chk(desc_ready == 1'b1, "R1", "ready in idle", desc_ready, 1);
        desc_valid = 1'b1; desc_addr = addr; desc_bytes = bytes;
        desc_incr = incr; cap_len = 8'(cap);
        @(negedge clk);
        desc_valid = 1'b0;
        desc_addr = $urandom; desc_bytes = $urandom; desc_incr = ~incr;
        cap_len = 8'($urandom);                       // R5: must not affect
        a = addr & ~32'(BB - 1);
        total = (longint'(bytes) + BB - 1) / BB;
        rem = total; sum = 0; held = 1'b0;
        if (rem == 0) begin
            chk(done == 1'b1, "R10", "done after empty desc", done, 1);
            chk(req_valid == 1'b0, "R10", "no request for empty desc", req_valid, 0);
            @(negedge clk);
            chk(done == 1'b0, "R10", "done width", done, 0);
            return;
        end
        forever begin
            if (junk) desc_valid = 1'($urandom);
            if (held && req_valid) begin
                chk(req_addr == h_addr && req_len == h_len, "R9", "held request",
                    {req_addr, req_len}, {h_addr, h_len});
            end
            held = 1'b0;
            req_ready = 1'b0;
            if (req_valid) begin
                req_ready = ($urandom % 4) != 0;
                if (!req_ready) begin
                    held = 1'b1; h_addr = req_addr; h_len = req_len;
                end
            end
            if (req_valid && req_ready) begin
                n = exp_beats(a, rem, incr, cap);
                chk(desc_ready == 1'b0, "R1", "busy ready", desc_ready, 0);
                chk(req_addr == a, "R7", "address", req_addr, a);
                chk(req_len == 8'(n - 1), "R6", "length", req_len, n - 1);
                chk(req_size == 3'(SZ), "R8", "size", req_size, SZ);
                chk(req_burst == (incr ? 2'b01 : 2'b00), "R8", "burst code", req_burst, incr);
                chk(req_len <= 8'(cap), "R5", "cap", req_len, cap);
                chk(req_len <= (incr ? 8'd255 : 8'd15), "R4", "mode limit", req_len, incr ? 255 : 15);
                if (incr)
                    chk(int'(req_addr[11:0]) + (int'(req_len) + 1) * BB <= 4096, "R3",
                        "page end", int'(req_addr[11:0]) + (int'(req_len) + 1) * BB, 4096);
                sum += longint'(req_len) + 1;
                rem -= n;
                if (incr) a = a + 32'(n * BB);
                @(negedge clk);
                req_ready = 1'b0;
                desc_valid = 1'b0;
                if (rem <= 0) begin
                    chk(done == 1'b1, "R10", "done after last", done, 1);
                    chk(sum == total, "R2", "beat total", sum, total);
                    @(negedge clk);
                    chk(done == 1'b0, "R10", "done width", done, 0);
                    chk(desc_ready == 1'b1, "R1", "back to idle", desc_ready, 1);
                    return;
                end else begin
                    chk(done == 1'b0, "R10", "early done", done, 0);
                end
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        rst_n = 1'b0; desc_valid = 1'b0; req_ready = 1'b0; desc_addr = '0;
        desc_bytes = '0; desc_incr = 1'b0; cap_len = '0;
        repeat (3) @(negedge clk);
        chk(desc_ready == 1'b1 && req_valid == 1'b0 && done == 1'b0, "R1", "reset state",
            {desc_ready, req_valid, done}, 3'b100);
        rst_n = 1'b1;
        // directed corners
        run_desc(32'h0000_0FF8, 64, 1'b1, 255, 1'b0);   // R3 page crossing
        run_desc(32'h0000_2000, 1000, 1'b0, 255, 1'b0); // R4 fixed 16 beats
        run_desc(32'h0000_1003, 5, 1'b1, 255, 1'b0);    // R2 unaligned start
        run_desc(32'h0000_0040, 0, 1'b1, 7, 1'b0);      // R10 empty
        run_desc(32'h0000_0100, 40, 1'b1, 0, 1'b1);     // R5 cap zero, R1 junk
        run_desc(32'h0000_0000, 4096, 1'b1, 255, 1'b0); // R4 256 beats
        run_desc(32'h0000_0800, 4096, 1'b1, 255, 1'b0); // R3 split at page
        run_desc(32'h0000_3001, 2, 1'b0, 3, 1'b0);      // R7 fixed address
        // constrained random
        for (int i = 0; i < 40; i++) begin
            logic [31:0] ra;
            int rb, rc;
            ra = $urandom;
            rb = int'($urandom % 3000);
            rc = ($urandom % 3 == 0) ? int'($urandom % 8) : int'($urandom % 256);
            run_desc(ra, 32'(rb), 1'($urandom), rc, 1'($urandom));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule